// File: doc/BRIEF.md
# Resume-After-Reset Shutdown Guard

This block decides whether an LED driver comes back into its running state after a reset trigger or stays in shutdown. It holds the driver's run bit and an automatic-resume bit. When the resume bit is set and a reset trigger arrives, the block forces shutdown and opens a window of 127 PWM-clock periods. If the serial slave reports a match on this device's address before the window closes, automatic resume is cancelled. The resume bit is cleared and the driver stays in shutdown. If no match arrives, the block sets the run bit and clears the resume bit when the 127th period ends.

The PWM clock is the internal oscillator or an external oscillator input, and a source-select bit picks one. Both arrive as raw levels from another clock domain. Each is synchronised into the system clock domain, and only rising edges of the selected source count down the window. Host configuration writes load the run, resume and source-select bits together in one strobe.

Top module: `shutdown_resume_timer`

## Requirements
- R1: While reset is asserted and on its release, `run_o`, `resume_o` and `ext_sel_o` are all 0.
- R2: A `cfg_wr` pulse loads `cfg_run`, `cfg_resume` and `cfg_ext_sel` into `run_o`, `resume_o` and `ext_sel_o` on the next clock edge.
- R3: A `trig` pulse while `resume_o` is 1 and no window is open clears `run_o`, leaves `resume_o` at 1, and opens a window of 127 rising edges of the selected PWM source.
- R4: The window expires on its 127th counted rising edge. `run_o` then goes to 1 and `resume_o` to 0 within 3 system clocks of that edge, and neither changes after 126 edges.
- R5: An `addr_hit` pulse while the window is open clears `resume_o`, keeps `run_o` at 0 and closes the window. Later PWM edges change nothing. If the hit coincides with the final edge, the hit wins.
- R6: With `ext_sel_o` 0 the internal source `osc_int_i` is counted, and with `ext_sel_o` 1 the external input `osc_ext_i` is counted. Edges on the unselected source have no effect.
- R7: A `trig` pulse while `resume_o` is 0 has no effect; `run_o` keeps its value.
- R8: An `addr_hit` pulse while no window is open has no effect on `run_o` or `resume_o`.
- R9: A `trig` pulse while a window is open is ignored and does not restart the count.
- R10: A `cfg_wr` pulse while a window is open closes the window, and the written values take effect. A further `trig` then opens a fresh full window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| osc_int_i | input | 1 | Internal oscillator level, asynchronous |
| osc_ext_i | input | 1 | External oscillator level, asynchronous |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_run | input | 1 | Run bit value to write |
| cfg_resume | input | 1 | Automatic-resume bit value to write |
| cfg_ext_sel | input | 1 | PWM source select to write (1 = external) |
| trig | input | 1 | Reset trigger pulse |
| addr_hit | input | 1 | Slave address match strobe |
| run_o | output | 1 | Current run bit (1 = driver running) |
| resume_o | output | 1 | Current automatic-resume bit |
| ext_sel_o | output | 1 | Current PWM source select |

## Verification
Configuration writes, triggers and address hits act on the first clock edge after the strobe, so the bench checks them at the following falling edge. A PWM edge passes two synchroniser flops and then updates the run and resume bits, so those results are due on the third system edge after the oscillator rises. The bench drives each oscillator half-period for four clocks and samples only after a full high and low phase, which lands well past that latency and before the next edge is generated. Cancellation points are swept over the window in steps of nine edges up to edge 126 for both sources, and the exact boundary between 126 and 127 edges is checked on both.

// File: rtl/resume_pkg.sv
package resume_pkg;

  // Number of PWM-clock periods in the cancellation window.
  localparam int unsigned WINDOW_LEN_DEF = 127;

  // Control bits kept by the guard.
  typedef struct packed {
    logic run;
    logic resume;
    logic ext_sel;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{run: 1'b0, resume: 1'b0, ext_sel: 1'b0};

endpackage

// File: rtl/reset_sync.sv
module reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/osc_edge_sync.sv
module osc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], lvl_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/window_counter.sv
module window_counter #(
  parameter int unsigned WINDOW_LEN = 127,
  localparam int unsigned CNT_W     = $clog2(WINDOW_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic tick_i,
  output logic open_o,
  output logic final_o
);

  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WINDOW_LEN);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (stop_i) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (start_i) begin
      cnt_d  = LOAD_VAL;
      cnt_en = 1'b1;
    end else if (tick_i && open_o) begin
      cnt_d  = cnt_q - ONE;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign open_o  = (cnt_q != '0);
  assign final_o = (cnt_q == ONE);

endmodule

// File: rtl/shutdown_resume_timer.sv
module shutdown_resume_timer
  import resume_pkg::*;
#(
  parameter int unsigned WINDOW_LEN  = WINDOW_LEN_DEF,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_int_i,
  input  logic osc_ext_i,
  input  logic cfg_wr,
  input  logic cfg_run,
  input  logic cfg_resume,
  input  logic cfg_ext_sel,
  input  logic trig,
  input  logic addr_hit,
  output logic run_o,
  output logic resume_o,
  output logic ext_sel_o
);

  localparam int unsigned NUM_SRC = 2;

  logic               srst_n;
  logic [NUM_SRC-1:0] osc_lvl;
  logic [NUM_SRC-1:0] osc_rise;
  logic               tick_sel;
  logic               win_open;
  logic               win_final;
  logic               win_start;
  logic               win_stop;
  ctl_t               ctl_q;
  ctl_t               ctl_d;
  logic               ctl_en;

  reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign osc_lvl = {osc_ext_i, osc_int_i};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    osc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (srst_n),
      .lvl_i  (osc_lvl[s]),
      .rise_o (osc_rise[s])
    );
  end

  assign tick_sel = ctl_q.ext_sel ? osc_rise[1] : osc_rise[0];

  window_counter #(.WINDOW_LEN(WINDOW_LEN)) u_win (
    .clk     (clk),
    .rst_n   (srst_n),
    .start_i (win_start),
    .stop_i  (win_stop),
    .tick_i  (tick_sel),
    .open_o  (win_open),
    .final_o (win_final)
  );

  // Next-state: host write first, then window events, then a new trigger.
  always_comb begin
    ctl_d     = ctl_q;
    ctl_en    = 1'b0;
    win_start = 1'b0;
    win_stop  = 1'b0;
    if (cfg_wr) begin
      ctl_d     = '{run: cfg_run, resume: cfg_resume, ext_sel: cfg_ext_sel};
      ctl_en    = 1'b1;
      win_stop  = win_open;
    end else if (win_open) begin
      if (addr_hit) begin
        ctl_d.resume = 1'b0;
        ctl_en       = 1'b1;
        win_stop     = 1'b1;
      end else if (tick_sel && win_final) begin
        ctl_d.run    = 1'b1;
        ctl_d.resume = 1'b0;
        ctl_en       = 1'b1;
        win_stop     = 1'b1;
      end
    end else if (trig && ctl_q.resume) begin
      ctl_d.run = 1'b0;
      ctl_en    = 1'b1;
      win_start = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctl_q <= CTL_RESET;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

  assign run_o     = ctl_q.run;
  assign resume_o  = ctl_q.resume;
  assign ext_sel_o = ctl_q.ext_sel;

endmodule

// File: rtl/shutdown_resume_timer_chk.sv
module shutdown_resume_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_wr,
  input logic trig,
  input logic addr_hit,
  input logic win_open,
  input logic run_o,
  input logic resume_o
);

  // R4
  run_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_o) |-> ($past(win_open) || $past(cfg_wr)));

  // R5
  cancel_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && addr_hit && !cfg_wr) |=> (!run_o && !resume_o && !win_open));

  // R7
  idle_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!resume_o && !win_open && trig && !cfg_wr) |=> ($stable(run_o) && !win_open));

  // R8
  stray_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_open && addr_hit && !trig && !cfg_wr) |=> ($stable(run_o) && $stable(resume_o)));

  // R3
  window_needs_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> (resume_o && !run_o));

endmodule

bind shutdown_resume_timer shutdown_resume_timer_chk u_chk (
  .clk      (clk),
  .rst_n    (srst_n),
  .cfg_wr   (cfg_wr),
  .trig     (trig),
  .addr_hit (addr_hit),
  .win_open (win_open),
  .run_o    (run_o),
  .resume_o (resume_o)
);

// File: tb/tb_shutdown_resume_timer.sv
`timescale 1ns/1ps
module tb_shutdown_resume_timer;

  logic clk = 1'b0;
  logic rst_n;
  logic osc_int_i, osc_ext_i;
  logic cfg_wr, cfg_run, cfg_resume, cfg_ext_sel;
  logic trig, addr_hit;
  logic run_o, resume_o, ext_sel_o;

  int n_vec  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  shutdown_resume_timer dut (
    .clk(clk), .rst_n(rst_n), .osc_int_i(osc_int_i), .osc_ext_i(osc_ext_i),
    .cfg_wr(cfg_wr), .cfg_run(cfg_run), .cfg_resume(cfg_resume),
    .cfg_ext_sel(cfg_ext_sel), .trig(trig), .addr_hit(addr_hit),
    .run_o(run_o), .resume_o(resume_o), .ext_sel_o(ext_sel_o)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_state(input string tag, input logic run_e, input logic res_e);
    check({tag, " run"}, run_o, run_e);
    check({tag, " resume"}, resume_o, res_e);
  endtask

  task automatic write_cfg(input logic r, input logic a, input logic s);
    @(negedge clk);
    cfg_run = r; cfg_resume = a; cfg_ext_sel = s; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic pulse_hit();
    @(negedge clk); addr_hit = 1'b1;
    @(negedge clk); addr_hit = 1'b0;
  endtask

  // One full period of a source: 4 clocks high, 4 low, ends on a falling edge.
  task automatic osc_period(input logic src_ext);
    @(negedge clk);
    if (src_ext) osc_ext_i = 1'b1; else osc_int_i = 1'b1;
    repeat (4) @(negedge clk);
    if (src_ext) osc_ext_i = 1'b0; else osc_int_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic osc_n(input logic src_ext, input int n);
    for (int i = 0; i < n; i++) osc_period(src_ext);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    osc_int_i = 0; osc_ext_i = 0;
    cfg_wr = 0; cfg_run = 0; cfg_resume = 0; cfg_ext_sel = 0;
    trig = 0; addr_hit = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check_state("R1 in reset", 1'b0, 1'b0);
    check("R1 in reset sel", ext_sel_o, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_state("R1 after release", 1'b0, 1'b0);

    // R2 load, R7 trigger with resume clear, R8 stray hit
    write_cfg(1'b1, 1'b0, 1'b1);
    check_state("R2 load", 1'b1, 1'b0);
    check("R2 sel", ext_sel_o, 1'b1);
    pulse_trig();
    check_state("R7 idle trigger", 1'b1, 1'b0);
    osc_n(1'b1, 130);
    check_state("R7 no window opened", 1'b1, 1'b0);
    write_cfg(1'b0, 1'b1, 1'b0);
    pulse_hit();
    check_state("R8 hit outside window", 1'b0, 1'b1);

    // Sweep cancellation point and expiry for both sources
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k <= 126; k += 9) begin
        write_cfg(1'b1, 1'b1, s[0]);
        pulse_trig();
        check_state("R3 window opened", 1'b0, 1'b1);
        osc_n(~s[0], 5);
        osc_n(s[0], k);
        check_state("R6 armed before hit", 1'b0, 1'b1);
        pulse_hit();
        check_state("R5 cancel", 1'b0, 1'b0);
        osc_n(s[0], 3);
        check_state("R5 ticks after cancel", 1'b0, 1'b0);
      end
      write_cfg(1'b1, 1'b1, s[0]);
      pulse_trig();
      osc_n(~s[0], 140);
      check_state("R6 unselected source ignored", 1'b0, 1'b1);
      osc_n(s[0], 126);
      check_state("R4 not expired at 126", 1'b0, 1'b1);
      osc_n(s[0], 1);
      check_state("R4 expired at 127", 1'b1, 1'b0);
    end

    // R9 retrigger ignored
    write_cfg(1'b1, 1'b1, 1'b0);
    pulse_trig();
    osc_n(1'b0, 60);
    pulse_trig();
    osc_n(1'b0, 66);
    check_state("R9 still open at 126", 1'b0, 1'b1);
    osc_n(1'b0, 1);
    check_state("R9 expiry not restarted", 1'b1, 1'b0);

    // R10 write during window closes it
    write_cfg(1'b1, 1'b1, 1'b1);
    pulse_trig();
    osc_n(1'b1, 10);
    write_cfg(1'b0, 1'b1, 1'b1);
    check_state("R10 write takes effect", 1'b0, 1'b1);
    osc_n(1'b1, 130);
    check_state("R10 window closed", 1'b0, 1'b1);
    pulse_trig();
    osc_n(1'b1, 126);
    check_state("R10 fresh window at 126", 1'b0, 1'b1);
    osc_n(1'b1, 1);
    check_state("R10 fresh window expiry", 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule